// File: doc/BRIEF.md
# Pruned Thirty-Column Block Interleaver and Deinterleaver

This block reorders one frame of symbols at a time through a matrix of 30 columns. In interleave mode the symbols of a frame enter in natural order and leave column by column: the columns are visited in a fixed scrambled order, and each column is read from top to bottom. Matrix cells that lie beyond the frame length are skipped without a gap in the output, so a frame of L symbols always yields exactly L symbols. In deinterleave mode the same sweep is used in reverse: the k-th received symbol is written to the k-th position of the sweep, and the restored frame is read out in natural order.

Frames arrive and leave on valid/ready streams. The length and the mode of each frame are taken from side inputs on the frame's first symbol. Two frame buffers work in ping-pong fashion, so the next frame can be written while the previous one is read out. A write state machine (`WR_IDLE`, `WR_FILL`) fills the buffers. A read state machine (`RD_IDLE`, `RD_STREAM`, `RD_DROP`) empties them. Transitions: `WR_IDLE`→`WR_FILL` on an accepted first symbol when L>1, `WR_FILL`→`WR_IDLE` on the L-th symbol. `RD_IDLE`→`RD_STREAM` when the next buffer is full with a valid mode, `RD_IDLE`→`RD_DROP` when it is full with an invalid mode, `RD_STREAM`→`RD_IDLE` when the last symbol is accepted, and `RD_DROP`→`RD_IDLE` after one cycle.

Top module: `col_interleaver`

## Requirements
- R1: During and after a synchronous active-high reset, `in_ready` is 1 and `out_valid` is 0, and both buffers are empty.
- R2: Input symbol n of a frame sits in row n/30 and column n mod 30, at linear position row*30+column. In interleave mode (`in_mode` = 2'b01) the output visits the column order 0,20,10,5,15,25,3,13,23,8,18,28,1,11,21,6,16,26,4,14,24,19,9,29,12,2,7,22,27,17. Within each column it emits rows 0 upward, and the row count is ceil(L/30).
- R3: Any position at or beyond L is skipped with no output and no idle cycle. Exactly L symbols leave for each valid frame, also when L is below 30 or not a multiple of 30.
- R4: In deinterleave mode (`in_mode` = 2'b11) the k-th input symbol is stored at the k-th unpruned position of the R2 sweep. The frame is then emitted in position order 0..L-1, which exactly undoes R2.
- R5: A frame whose mode is neither 2'b01 nor 2'b11 is fully accepted and then discarded with no output symbol.
- R6: No output symbol of a frame appears before all L of its input symbols have been accepted.
- R7: `in_len` and `in_mode` are sampled only with the first symbol of a frame. Their values during the later symbols of the frame have no effect.
- R8: A second frame is accepted while the first is held unread. `in_ready` is 0 when both buffers hold frames that have not been fully read.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged.
- R10: `out_last` is 1 only together with the L-th output symbol of a frame.
- R11: A sampled length of 0 is treated as 1, and a length above LMAX is treated as LMAX.
- R12: Frames stream back to back under output back-pressure, and each frame keeps its own length and mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input symbol valid |
| in_ready | output | 1 | Block can take an input symbol |
| in_data | input | W | Input symbol |
| in_len | input | LW | Frame length, sampled on the first symbol |
| in_mode | input | 2 | 2'b01 interleave, 2'b11 deinterleave, other values discard, sampled on the first symbol |
| out_valid | output | 1 | Output symbol valid |
| out_ready | input | 1 | Downstream takes the output symbol |
| out_data | output | W | Output symbol |
| out_last | output | 1 | Marks the final symbol of a frame |

## Verification
A wrong column or row step in the sweep generator shows up as a wrong symbol in the same frame, at the first output of the column where the step goes astray. A wrong pruning bound shows up as a short or long frame, with `out_last` out of place on that frame's final beat. A stuck buffer flag shows up a frame later: either `in_ready` never returns, or a stale or missing frame appears, and the next expected symbol then fails to match. Back-pressure faults show up as a changed `out_data` while the output is held.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    localparam int NCOL = 30;

    typedef enum logic [1:0] {
        MODE_NONE = 2'd0,
        MODE_ILV  = 2'd1,
        MODE_DILV = 2'd2
    } frame_mode_e;

    // Column visiting order of the sweep.
    function automatic logic [4:0] col_perm(input logic [4:0] idx);
        logic [4:0] c;
        unique case (idx)
            5'd0:  c = 5'd0;
            5'd1:  c = 5'd20;
            5'd2:  c = 5'd10;
            5'd3:  c = 5'd5;
            5'd4:  c = 5'd15;
            5'd5:  c = 5'd25;
            5'd6:  c = 5'd3;
            5'd7:  c = 5'd13;
            5'd8:  c = 5'd23;
            5'd9:  c = 5'd8;
            5'd10: c = 5'd18;
            5'd11: c = 5'd28;
            5'd12: c = 5'd1;
            5'd13: c = 5'd11;
            5'd14: c = 5'd21;
            5'd15: c = 5'd6;
            5'd16: c = 5'd16;
            5'd17: c = 5'd26;
            5'd18: c = 5'd4;
            5'd19: c = 5'd14;
            5'd20: c = 5'd24;
            5'd21: c = 5'd19;
            5'd22: c = 5'd9;
            5'd23: c = 5'd29;
            5'd24: c = 5'd12;
            5'd25: c = 5'd2;
            5'd26: c = 5'd7;
            5'd27: c = 5'd22;
            5'd28: c = 5'd27;
            5'd29: c = 5'd17;
            default: c = 5'd0;
        endcase
        return c;
    endfunction

    function automatic frame_mode_e decode_mode(input logic [1:0] m);
        frame_mode_e r;
        unique case (m)
            2'b01:   r = MODE_ILV;
            2'b11:   r = MODE_DILV;
            default: r = MODE_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ilv_sweep.sv
module ilv_sweep
    import ilv_pkg::*;
#(
    parameter int LMAX = 1024,
    parameter int AW   = $clog2(LMAX),
    parameter int LW   = $clog2(LMAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          step,
    input  logic [LW-1:0] len,
    output logic [AW-1:0] pos
);

    localparam int ROWS_MAX = (LMAX + NCOL - 1) / NCOL;
    localparam int RW       = $clog2(ROWS_MAX + 1);

    logic [4:0]    idx_q, idx_n;
    logic [RW-1:0] row_q, row_n;
    logic [4:0]    col_c;
    int            rows, fill, height;
    logic          found;

    always_comb begin
        rows   = (int'(len) + NCOL - 1) / NCOL;
        fill   = int'(len) - NCOL * (rows - 1);
        col_c  = col_perm(idx_q);
        height = (int'(col_c) < fill) ? rows : rows - 1;
        pos    = AW'(int'(row_q) * NCOL + int'(col_c));
    end

    // Next unpruned cell: go down the column, else jump to the next
    // column that holds at least one cell below L.
    always_comb begin
        idx_n = 5'd0;
        row_n = '0;
        found = 1'b0;
        if (int'(row_q) + 1 < height) begin
            idx_n = idx_q;
            row_n = row_q + RW'(1);
        end else begin
            for (int k = 1; k < NCOL; k++) begin
                if (!found && (k > int'(idx_q)) &&
                    ((rows > 1) || (int'(col_perm(5'(k))) < fill))) begin
                    idx_n = 5'(k);
                    found = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            idx_q <= 5'd0;
            row_q <= '0;
        end else if (step) begin
            idx_q <= idx_n;
            row_q <= row_n;
        end
    end

    AST_SWEEP_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(idx_q) < NCOL); // R2

    AST_SWEEP_ROW_MOVES: assert property (@(posedge clk) disable iff (rst)
        (step && !clear && int'(row_q) + 1 < height) |=> (row_q == $past(row_q) + RW'(1))); // R2

endmodule

// File: rtl/ilv_store.sv
module ilv_store #(
    parameter int W     = 8,
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/col_interleaver.sv
module col_interleaver
    import ilv_pkg::*;
#(
    parameter int W    = 8,
    parameter int LMAX = 1024,
    parameter int LW   = $clog2(LMAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [W-1:0]  in_data,
    input  logic [LW-1:0] in_len,
    input  logic [1:0]    in_mode,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [W-1:0]  out_data,
    output logic          out_last
);

    localparam int AW     = $clog2(LMAX);
    localparam int NBANK  = 2;

    typedef enum logic {WR_IDLE, WR_FILL} wr_state_e;
    typedef enum logic [1:0] {RD_IDLE, RD_STREAM, RD_DROP} rd_state_e;

    wr_state_e   wr_state, wr_state_n;
    rd_state_e   rd_state, rd_state_n;

    logic [NBANK-1:0] full_q;
    logic [LW-1:0]    blen_q  [NBANK];
    frame_mode_e      bmode_q [NBANK];
    logic             wbank_q, rbank_q;

    // ---------------- write side ----------------
    logic [LW-1:0] len_clamped, wr_len_q, wr_len_eff, wr_cnt_q;
    frame_mode_e   wr_mode_q, wr_mode_eff;
    logic          wr_fire, wr_last;
    logic [AW-1:0] wgen_pos, waddr;

    always_comb begin
        if (in_len == '0) begin
            len_clamped = LW'(1);
        end else if (int'(in_len) > LMAX) begin
            len_clamped = LW'(LMAX);
        end else begin
            len_clamped = in_len;
        end
        wr_len_eff  = (wr_state == WR_IDLE) ? len_clamped : wr_len_q;
        wr_mode_eff = (wr_state == WR_IDLE) ? decode_mode(in_mode) : wr_mode_q;
        in_ready    = !full_q[wbank_q];
        wr_fire     = in_valid && in_ready;
        wr_last     = wr_fire && (wr_cnt_q == wr_len_eff - LW'(1));
        waddr       = (wr_mode_eff == MODE_DILV) ? wgen_pos : wr_cnt_q[AW-1:0];
    end

    ilv_sweep #(.LMAX(LMAX), .AW(AW), .LW(LW)) u_wr_sweep (
        .clk   (clk),
        .rst   (rst),
        .clear (wr_last),
        .step  (wr_fire),
        .len   (wr_len_eff),
        .pos   (wgen_pos)
    );

    always_comb begin
        wr_state_n = wr_state;
        unique case (wr_state)
            WR_IDLE: if (wr_fire && !wr_last) wr_state_n = WR_FILL;
            WR_FILL: if (wr_last)             wr_state_n = WR_IDLE;
            default:                          wr_state_n = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_state <= WR_IDLE;
        end else begin
            wr_state <= wr_state_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_cnt_q  <= '0;
            wr_len_q  <= LW'(1);
            wr_mode_q <= MODE_NONE;
        end else if (wr_fire) begin
            wr_cnt_q <= wr_last ? '0 : wr_cnt_q + LW'(1);
            if (wr_state == WR_IDLE) begin
                wr_len_q  <= len_clamped;
                wr_mode_q <= decode_mode(in_mode);
            end
        end
    end

    // ---------------- read side ----------------
    logic [LW-1:0] rd_len, rd_cnt_q;
    frame_mode_e   rd_mode;
    logic          out_fire, rd_final, release_bank;
    logic [AW-1:0] rgen_pos, raddr;
    logic [W-1:0]  rdata [NBANK];

    always_comb begin
        rd_len       = blen_q[rbank_q];
        rd_mode      = bmode_q[rbank_q];
        out_fire     = out_valid && out_ready;
        rd_final     = (rd_cnt_q == rd_len - LW'(1));
        release_bank = (rd_state == RD_DROP) ||
                       ((rd_state == RD_STREAM) && out_fire && rd_final);
        raddr        = (rd_mode == MODE_ILV) ? rgen_pos : rd_cnt_q[AW-1:0];
    end

    ilv_sweep #(.LMAX(LMAX), .AW(AW), .LW(LW)) u_rd_sweep (
        .clk   (clk),
        .rst   (rst),
        .clear (release_bank),
        .step  (out_fire),
        .len   (rd_len),
        .pos   (rgen_pos)
    );

    always_comb begin
        rd_state_n = rd_state;
        unique case (rd_state)
            RD_IDLE: begin
                if (full_q[rbank_q]) begin
                    rd_state_n = (rd_mode == MODE_NONE) ? RD_DROP : RD_STREAM;
                end
            end
            RD_STREAM: if (out_fire && rd_final) rd_state_n = RD_IDLE;
            RD_DROP:                              rd_state_n = RD_IDLE;
            default:                              rd_state_n = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_state <= RD_IDLE;
        end else begin
            rd_state <= rd_state_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_cnt_q <= '0;
        end else if (release_bank) begin
            rd_cnt_q <= '0;
        end else if (out_fire) begin
            rd_cnt_q <= rd_cnt_q + LW'(1);
        end
    end

    // ---------------- bank bookkeeping ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            full_q  <= '0;
            wbank_q <= 1'b0;
            rbank_q <= 1'b0;
            for (int b = 0; b < NBANK; b++) begin
                blen_q[b]  <= LW'(1);
                bmode_q[b] <= MODE_NONE;
            end
        end else begin
            if (wr_last) begin
                full_q[wbank_q]  <= 1'b1;
                blen_q[wbank_q]  <= wr_len_eff;
                bmode_q[wbank_q] <= wr_mode_eff;
                wbank_q          <= ~wbank_q;
            end
            if (release_bank) begin
                full_q[rbank_q] <= 1'b0;
                rbank_q         <= ~rbank_q;
            end
        end
    end

    // ---------------- storage ----------------
    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        ilv_store #(.W(W), .DEPTH(LMAX), .AW(AW)) u_store (
            .clk   (clk),
            .we    (wr_fire && (wbank_q == 1'(g))),
            .waddr (waddr),
            .wdata (in_data),
            .raddr (raddr),
            .rdata (rdata[g])
        );
    end

    // ---------------- outputs ----------------
    always_comb begin
        out_valid = (rd_state == RD_STREAM);
        out_last  = (rd_state == RD_STREAM) && rd_final;
        out_data  = rdata[rbank_q];
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9

    AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid); // R10

    AST_OUT_FROM_FULL_BANK: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> full_q[rbank_q]); // R6

    AST_WADDR_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        wr_fire |-> (int'(waddr) < int'(wr_len_eff))); // R3

    AST_RADDR_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (int'(raddr) < int'(rd_len))); // R3

    AST_LEN_CLAMPED: assert property (@(posedge clk) disable iff (rst)
        wr_fire |-> (wr_len_eff != '0 && int'(wr_len_eff) <= LMAX)); // R11

endmodule

// File: tb/col_interleaver_tb.sv
module col_interleaver_tb;

    localparam int W    = 8;
    localparam int LMAX = 1024;
    localparam int LW   = $clog2(LMAX + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [W-1:0]  in_data = '0;
    logic [LW-1:0] in_len = '0;
    logic [1:0]    in_mode = 2'b00;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [W-1:0]  out_data;
    logic          out_last;

    always #2 clk = ~clk;   // 250 MHz

    col_interleaver #(.W(W), .LMAX(LMAX)) u_dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_len(in_len), .in_mode(in_mode),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [W:0] exp_q [$];
    string      tag_q [$];
    int         col_tab [30];

    logic [1:0] bp_mode = 2'd0;  // 0 always ready, 1 pseudo-random, 2 held low
    logic [15:0] lfsr = 16'hACE1;

    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        unique case (bp_mode)
            2'd0:    out_ready = 1'b1;
            2'd1:    out_ready = lfsr[0] | lfsr[3];
            default: out_ready = 1'b0;
        endcase
    end

    // Monitor: compare each accepted output against the scoreboard.
    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL unexpected output (R3/R5): got data=%0h last=%0b, expected none",
                         out_data, out_last);
            end else begin
                logic [W:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({out_last, out_data} !== e) begin
                    n_bad++;
                    $display("FAIL %s: got last=%0b data=%0h, expected last=%0b data=%0h",
                             t, out_last, out_data, e[W], e[W-1:0]);
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Driver: builds the expected output of a frame, then sends the frame.
    task automatic send_frame(input int len_req, input logic [1:0] mode, input int seed,
                              input string tag, input bit gaps, input bit no_out_chk);
        int L, rows, k;
        int din [LMAX];
        int dout [LMAX];
        L = (len_req == 0) ? 1 : (len_req > LMAX ? LMAX : len_req);
        rows = (L + 29) / 30;
        for (int n = 0; n < L; n++) din[n] = (seed + n * 37 + n / 11) & 255;
        if (mode == 2'b01) begin
            k = 0;
            for (int i = 0; i < 30; i++)
                for (int j = 0; j < rows; j++)
                    if (j * 30 + col_tab[i] < L) begin
                        k++;
                        exp_q.push_back({1'(k == L), 8'(din[j * 30 + col_tab[i]])});
                        tag_q.push_back(tag);
                    end
        end else if (mode == 2'b11) begin
            k = 0;
            for (int i = 0; i < 30; i++)
                for (int j = 0; j < rows; j++)
                    if (j * 30 + col_tab[i] < L) begin
                        dout[j * 30 + col_tab[i]] = din[k];
                        k++;
                    end
            for (int n = 0; n < L; n++) begin
                exp_q.push_back({1'(n == L - 1), 8'(dout[n])});
                tag_q.push_back(tag);
            end
        end
        for (int n = 0; n < L; n++) begin
            bit acc;
            if (gaps && lfsr[5]) begin
                in_valid = 1'b0;
                @(posedge clk); #1;
            end
            in_valid = 1'b1;
            in_data  = 8'(din[n]);
            // R7: only the first symbol carries meaningful length and mode
            in_len   = (n == 0) ? LW'(len_req) : LW'(lfsr[10:0]);
            in_mode  = (n == 0) ? mode : lfsr[1:0];
            do begin
                @(negedge clk);
                acc = in_ready;
                if (no_out_chk) check(!out_valid, "R6 output before frame complete", int'(out_valid), 0);
                @(posedge clk); #1;
            end while (!acc);
        end
        in_valid = 1'b0;
    endtask

    task automatic drain();
        int t = 0;
        while ((exp_q.size() != 0 || out_valid) && t < 20000) begin
            @(posedge clk); #1;
            t++;
        end
        repeat (4) @(posedge clk);
        #1;
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d cycles expected below 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int pv [30] = '{0,20,10,5,15,25,3,13,23,8,18,28,1,11,21,6,16,26,4,14,24,19,9,29,12,2,7,22,27,17};
        for (int i = 0; i < 30; i++) col_tab[i] = pv[i];

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(in_ready === 1'b1, "R1 in_ready in reset", int'(in_ready), 1);
        check(out_valid === 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        check(in_ready === 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
        check(out_valid === 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        @(posedge clk); #1;

        // R2 full matrix, R6 no output while filling
        send_frame(60, 2'b01, 3, "R2 interleave L=60", 0, 1);
        drain();
        // R3 pruning below one row and ragged last row
        send_frame(7, 2'b01, 11, "R3 interleave L=7", 0, 1);
        drain();
        send_frame(61, 2'b01, 19, "R3 interleave L=61", 1, 0);
        drain();
        send_frame(1, 2'b01, 5, "R3 interleave L=1", 0, 0);
        drain();
        // R4 deinterleave
        send_frame(61, 2'b11, 23, "R4 deinterleave L=61", 1, 0);
        drain();
        send_frame(29, 2'b11, 41, "R4 deinterleave L=29", 0, 0);
        drain();
        // R5 invalid mode is swallowed
        send_frame(20, 2'b00, 7, "R5 discarded frame", 0, 0);
        repeat (10) @(posedge clk);
        @(negedge clk);
        check(!out_valid, "R5 no output for invalid mode", int'(out_valid), 0);
        @(posedge clk); #1;
        send_frame(20, 2'b10, 7, "R5 discarded frame", 0, 0);
        send_frame(33, 2'b01, 77, "R5 frame after discard", 0, 0);
        drain();
        // R11 clamping
        send_frame(0, 2'b01, 9, "R11 length 0 as 1", 0, 0);
        drain();
        send_frame(1500, 2'b11, 13, "R11 length above max", 0, 0);
        drain();

        // R8 two frames held, R9 output held
        bp_mode = 2'd2;
        @(posedge clk); #1;
        send_frame(40, 2'b01, 50, "R8 held frame A", 0, 0);
        send_frame(40, 2'b11, 60, "R8 held frame B", 0, 0);
        in_valid = 1'b1;
        @(negedge clk);
        check(in_ready === 1'b0, "R8 in_ready with both buffers full", int'(in_ready), 0);
        check(out_valid === 1'b1, "R9 out_valid while held", int'(out_valid), 1);
        begin
            logic [W-1:0] held;
            held = out_data;
            repeat (3) @(negedge clk);
            check(out_data === held, "R9 data stable while held", int'(out_data), int'(held));
            check(out_valid === 1'b1, "R9 valid stays while held", int'(out_valid), 1);
        end
        in_valid = 1'b0;
        @(posedge clk); #1;
        bp_mode = 2'd1;
        drain();

        // R12 back to back under back-pressure, R10 last flag via scoreboard
        send_frame(1024, 2'b01, 91, "R12 stream frame 1", 1, 0);
        send_frame(45, 2'b11, 92, "R12 stream frame 2", 0, 0);
        send_frame(90, 2'b01, 93, "R12 stream frame 3", 1, 0);
        send_frame(1024, 2'b11, 94, "R12 stream frame 4", 0, 0);
        send_frame(2, 2'b01, 95, "R10 stream frame 5", 0, 0);
        drain();
        check(exp_q.size() == 0, "R3 all expected symbols produced", exp_q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule